// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Error Status

This block receives characters on one asynchronous serial line. It samples the line on an oversampling enable (`os_tick`) that runs at sixteen times the bit rate. The format inputs select 7 or 8 data bits, an optional parity bit with even or odd sense, and one or two stop bits. Data arrives least significant bit first. When a character is complete, it moves into a holding buffer. The receiver can then assemble the next character while the processor has not yet read the previous one.

A status byte reports the state of the buffer and four sticky error conditions: overrun, parity, framing, and a summary bit. These error flags are only updated when a character moves to the buffer, which happens at the centre of the first stop bit. The processor has three controls:

- A read strobe, which empties the buffer.
- A write strobe on the status byte, which clears the errors.
- An enable input. While this input is low, the receiver is held idle and every flag is cleared.

A one-cycle interrupt pulse marks each character that loads into the buffer.

Top module: `uart_rx_status`

## Requirements
- R1: Frame format. A frame is a low start bit, then 7 data bits (`cfg_len7`=1) or 8 data bits (`cfg_len7`=0) sent least significant bit first. A parity bit follows when `cfg_par_en`=1. Then come one stop bit, or two when `cfg_stop2`=1. Each bit lasts 16 `os_tick` pulses, and each data bit is sampled at its centre.
- R2: Start validation. A low level on an idle line is checked again after 8 ticks. If the line has returned high by then, it is discarded and no character results.
- R3: Buffer load. Loading a character into `rx_data` sets buffer-full (status bit 1) and pulses `rx_irq` high for exactly one clock.
- R4: A one-cycle `buf_rd` strobe clears buffer-full.
- R5: In 7-bit mode, bit 7 of `rx_data` reads 0.
- R6: Overrun. If a character completes while buffer-full is 1, the overrun flag (status bit 3) sets. In that case `rx_data` keeps the old character, no interrupt is raised, and the new character's parity and framing results are dropped.
- R7: Parity check.
  - The parity flag (status bit 4) sets when the received parity bit disagrees with the data bits.
  - With `cfg_par_odd`=0 the expected parity is even; with `cfg_par_odd`=1 it is odd.
  - The parity flag never sets when parity is disabled.
- R8: Framing. The framing flag (status bit 5) sets when the first stop bit is sampled low. After that, the receiver waits for the line to return high before it looks for a new start bit.
- R9: Summary and unused bits. Status bit 6 is the OR of bits 3, 4 and 5. Status bits 0, 2 and 7 read 0.
- R10: A `sts_wr` strobe clears status bits 3 to 6 and leaves buffer-full unchanged.
- R11: While `rx_en` is 0, every status flag reads 0 from the next clock, and frames on the line are ignored.
- R12: After reset, `status`, `rx_data` and `rx_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_en | input | 1 | Receiver enable; low clears all flags |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2 | input | 1 | Two stop bits |
| buf_rd | input | 1 | Read strobe for the receive buffer |
| sts_wr | input | 1 | Write strobe on the status byte; clears errors |
| rx_data | output | 8 | Receive buffer contents |
| status | output | 8 | Bit 1 full, 3 overrun, 4 parity, 5 framing, 6 summary |
| rx_irq | output | 1 | One-cycle pulse per buffer load |

## Verification
The two internal state items most likely to go wrong are the bit counter and the tick counter. An error in either would show up within one frame, in one of three ways:

- `rx_data` holds a shifted or misaligned character.
- A parity or framing flag appears on a clean frame.
- After a bad stop bit, a phantom character arrives.

A buffer-full flag that is stuck or released too early only shows up on the second character. It appears as an overrun that should not happen, a missing overrun, or a buffer overwritten with no read in between. The sticky error flags are checked after every frame against a model in the bench. This means a flag that clears or sets at the wrong moment is caught at the next frame boundary.

// File: rtl/uart_rx_pkg.sv
// Package: shared types and status bit positions for the serial receiver.
// Assumes one status byte whose bit positions are fixed by the software view.
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2,
        ST_WAITHI
    } rx_state_e;

    typedef struct packed {
        logic len7;
        logic par_en;
        logic par_odd;
        logic stop2;
    } rx_cfg_t;

    localparam int BIT_FULL = 1;
    localparam int BIT_OVR  = 3;
    localparam int BIT_PAR  = 4;
    localparam int BIT_FRM  = 5;
    localparam int BIT_SUM  = 6;

endpackage

// File: rtl/rx_line_sync.sv
// Module: two-flop synchronizer for the asynchronous serial input.
// Assumes the line idles high, so the reset value is 1.
module rx_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_in,
    output logic rxd_out
);
    logic meta_q;

    // Purpose: move the line into the clock domain through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= 1'b1;
            rxd_out <= 1'b1;
        end else begin
            meta_q  <= rxd_in;
            rxd_out <= meta_q;
        end
    end
endmodule

// File: rtl/rx_frame.sv
// Module: frame assembler. It counts oversampling ticks, validates the start
// bit at half a bit period, samples data, parity and stop bits at their
// centres, and raises done for one clock at the centre of the first stop bit.
// Assumes the configuration is stable while a frame is in flight.
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rx_en,
    input  logic          rxs,
    input  rx_cfg_t       cfg,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          perr,
    output logic          ferr
);
    localparam int CW   = $clog2(OS_RATE);
    localparam int BW   = $clog2(DW);
    localparam int HALF = OS_RATE / 2;

    rx_state_e      state_q;
    logic [CW-1:0]  cnt_q;
    logic [BW-1:0]  bidx_q;
    logic [DW-1:0]  shift_q;
    logic           par_acc_q;
    logic           perr_q;
    logic           bit_end;
    logic           half_end;
    logic [BW-1:0]  last_idx;

    assign bit_end  = (cnt_q == CW'(OS_RATE - 1));
    assign half_end = (cnt_q == CW'(HALF - 1));
    assign last_idx = cfg.len7 ? BW'(DW - 2) : BW'(DW - 1);

    // Purpose: character output, with the top bit forced to 0 in short mode.
    always_comb begin
        data = shift_q;
        if (cfg.len7) begin
            data = {1'b0, shift_q[DW-1:1]};
        end
    end

    // Purpose: the receive state machine and its tick and bit counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            bidx_q    <= '0;
            shift_q   <= '0;
            par_acc_q <= 1'b0;
            perr_q    <= 1'b0;
            done      <= 1'b0;
            perr      <= 1'b0;
            ferr      <= 1'b0;
        end else if (!rx_en) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (os_tick) begin
                case (state_q)
                    ST_IDLE: begin
                        cnt_q <= '0;
                        if (!rxs) begin
                            state_q <= ST_START;
                        end
                    end
                    ST_START: begin
                        if (half_end) begin
                            cnt_q     <= '0;
                            bidx_q    <= '0;
                            par_acc_q <= 1'b0;
                            state_q   <= rxs ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (bit_end) begin
                            cnt_q     <= '0;
                            shift_q   <= {rxs, shift_q[DW-1:1]};
                            par_acc_q <= par_acc_q ^ rxs;
                            bidx_q    <= bidx_q + 1'b1;
                            if (bidx_q == last_idx) begin
                                state_q <= cfg.par_en ? ST_PAR : ST_STOP1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (bit_end) begin
                            cnt_q   <= '0;
                            perr_q  <= (par_acc_q ^ rxs) ^ cfg.par_odd;
                            state_q <= ST_STOP1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_STOP1: begin
                        if (bit_end) begin
                            cnt_q   <= '0;
                            done    <= 1'b1;
                            ferr    <= !rxs;
                            perr    <= cfg.par_en & perr_q;
                            state_q <= cfg.stop2 ? ST_STOP2 : ST_WAITHI;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (bit_end) begin
                            cnt_q   <= '0;
                            state_q <= ST_WAITHI;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_WAITHI: begin
                        cnt_q <= '0;
                        if (rxs) begin
                            state_q <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_status.sv
// Module: receive buffer and status flags. A completed character loads the
// buffer if it is empty; otherwise overrun is flagged and the buffer is kept.
// Error flags are sticky until a status write; disable clears all flags.
module rx_status
    import uart_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          done,
    input  logic [DW-1:0] data,
    input  logic          perr,
    input  logic          ferr,
    input  logic          buf_rd,
    input  logic          sts_wr,
    output logic [DW-1:0] buf_q,
    output logic [7:0]    status,
    output logic          irq
);
    logic full_q, ovr_q, par_q, frm_q, sum_q;
    logic full_d, ovr_d, par_d, frm_d, load;

    // Purpose: next-state flags after read, write and completion events.
    always_comb begin
        full_d = full_q & !buf_rd;
        ovr_d  = ovr_q & !sts_wr;
        par_d  = par_q & !sts_wr;
        frm_d  = frm_q & !sts_wr;
        load   = 1'b0;
        if (done) begin
            if (full_d) begin
                ovr_d = 1'b1;
            end else begin
                load   = 1'b1;
                full_d = 1'b1;
                par_d  = par_d | perr;
                frm_d  = frm_d | ferr;
            end
        end
    end

    // Purpose: flag, buffer and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            par_q  <= 1'b0;
            frm_q  <= 1'b0;
            sum_q  <= 1'b0;
            irq    <= 1'b0;
            buf_q  <= '0;
        end else if (!rx_en) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            par_q  <= 1'b0;
            frm_q  <= 1'b0;
            sum_q  <= 1'b0;
            irq    <= 1'b0;
        end else begin
            full_q <= full_d;
            ovr_q  <= ovr_d;
            par_q  <= par_d;
            frm_q  <= frm_d;
            sum_q  <= ovr_d | par_d | frm_d;
            irq    <= load;
            if (load) begin
                buf_q <= data;
            end
        end
    end

    // Purpose: assemble the status byte at the fixed bit positions.
    always_comb begin
        status           = 8'h00;
        status[BIT_FULL] = full_q;
        status[BIT_OVR]  = ovr_q;
        status[BIT_PAR]  = par_q;
        status[BIT_FRM]  = frm_q;
        status[BIT_SUM]  = sum_q;
    end
endmodule

// File: rtl/uart_rx_status.sv
// Module: top of the oversampled serial receiver with buffer and error status.
// Assumes os_tick is a one-clock enable at sixteen times the bit rate.
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rx_en,
    input  logic          rxd,
    input  logic          cfg_len7,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_stop2,
    input  logic          buf_rd,
    input  logic          sts_wr,
    output logic [DW-1:0] rx_data,
    output logic [7:0]    status,
    output logic          rx_irq
);
    logic          rxs;
    logic          frm_done;
    logic [DW-1:0] frm_data;
    logic          frm_perr;
    logic          frm_ferr;
    rx_cfg_t       cfg;

    assign cfg = '{len7: cfg_len7, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, stop2: cfg_stop2};

    rx_line_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd_in  (rxd),
        .rxd_out (rxs)
    );

    rx_frame #(.OS_RATE(OS_RATE), .DW(DW)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .rx_en   (rx_en),
        .rxs     (rxs),
        .cfg     (cfg),
        .done    (frm_done),
        .data    (frm_data),
        .perr    (frm_perr),
        .ferr    (frm_ferr)
    );

    rx_status #(.DW(DW)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_en  (rx_en),
        .done   (frm_done),
        .data   (frm_data),
        .perr   (frm_perr),
        .ferr   (frm_ferr),
        .buf_rd (buf_rd),
        .sts_wr (sts_wr),
        .buf_q  (rx_data),
        .status (status),
        .irq    (rx_irq)
    );
endmodule

// File: rtl/uart_rx_status_chk.sv
// Module: property checker bound to the receiver top.
// Assumes it observes ports and the internal completion pulse only.
module uart_rx_status_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          buf_rd,
    input logic          sts_wr,
    input logic          frm_done,
    input logic [DW-1:0] rx_data,
    input logic [7:0]    status,
    input logic          rx_irq
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq); // R3

    AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> status[1]); // R3

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && buf_rd && !frm_done) |=> !status[1]); // R4

    AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && frm_done && status[1] && !buf_rd) |=> (status[3] && $stable(rx_data) && !rx_irq)); // R6

    AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] == (status[3] | status[4] | status[5])); // R9

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !frm_done) |=> (status[6:3] == 4'b0000)); // R10

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (status == 8'h00)); // R11
endmodule

bind uart_rx_status uart_rx_status_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .buf_rd   (buf_rd),
    .sts_wr   (sts_wr),
    .frm_done (frm_done),
    .rx_data  (rx_data),
    .status   (status),
    .rx_irq   (rx_irq)
);

// File: tb/uart_rx_status_tb.sv
`timescale 1ns/1ps
module uart_rx_status_tb;
    localparam int OS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick;
    logic rx_en = 1'b0;
    logic rxd = 1'b1;
    logic cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic buf_rd = 1'b0, sts_wr = 1'b0;
    logic [7:0] rx_data, status;
    logic rx_irq;

    int errors = 0, checks = 0, irq_cnt = 0, exp_irq = 0;
    int div = 1, tick_cnt = 0;
    logic e_full = 0, e_ovr = 0, e_par = 0, e_frm = 0;
    logic [7:0] e_buf = 8'h00;

    always #2.5 clk = ~clk;

    uart_rx_status u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en), .rxd(rxd),
        .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .buf_rd(buf_rd), .sts_wr(sts_wr),
        .rx_data(rx_data), .status(status), .rx_irq(rx_irq)
    );

    // tick generator: one pulse every div clocks
    always @(posedge clk) tick_cnt <= (tick_cnt + 1 >= div) ? 0 : tick_cnt + 1;
    assign os_tick = (tick_cnt == 0);

    always @(negedge clk) if (rx_irq) irq_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [7:0] s = 8'h00;
        s[1] = e_full; s[3] = e_ovr; s[4] = e_par; s[5] = e_frm;
        s[6] = e_ovr | e_par | e_frm;
        return s;
    endfunction

    function automatic logic [7:0] mask_char(input logic [7:0] d, input logic l7);
        return l7 ? {1'b0, d[6:0]} : d;
    endfunction

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (OS * div) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic l7, pe, po, s2, bp, bs);
        logic [7:0] m = mask_char(d, l7);
        logic pbit = (^m) ^ po ^ bp;
        cfg_len7 = l7; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
        drive_bit(1'b0);
        for (int i = 0; i < (l7 ? 7 : 8); i++) drive_bit(d[i]);
        if (pe) drive_bit(pbit);
        drive_bit(!bs);
        if (s2) drive_bit(1'b1);
        drive_bit(1'b1);
        if (rx_en) begin
            if (e_full) e_ovr = 1;
            else begin
                e_buf = m; e_full = 1; exp_irq++;
                e_par = e_par | (pe & bp);
                e_frm = e_frm | bs;
            end
        end
    endtask

    task automatic check_all(input string tag);
        repeat (3) @(negedge clk);
        chk(rx_data == e_buf, {tag, " data"}, rx_data, e_buf);
        chk(status == exp_status(), {tag, " status"}, status, exp_status());
        chk(irq_cnt == exp_irq, {tag, " irq"}, irq_cnt, exp_irq);
    endtask

    task automatic pulse_rd();
        buf_rd = 1; @(negedge clk); buf_rd = 0; e_full = 0; @(negedge clk);
    endtask

    task automatic pulse_wr();
        sts_wr = 1; @(negedge clk); sts_wr = 0; e_ovr = 0; e_par = 0; e_frm = 0; @(negedge clk);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #750000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        // R12 reset state
        chk(status == 8'h00 && rx_data == 8'h00 && rx_irq == 0, "R12 reset", status, 0);
        rst_n = 1; rx_en = 1;
        repeat (4) @(negedge clk);

        // R1 R3 basic 8N1
        send(8'hA5, 0, 0, 0, 0, 0, 0); check_all("R1 R3 8N1");
        // R4 read clears full
        pulse_rd(); chk(status[1] == 0, "R4 read", status, 0);
        // R5 seven-bit MSB zero
        send(8'hFF, 1, 0, 0, 0, 0, 0); check_all("R5 7bit");
        pulse_rd();
        // R6 overrun keeps old character
        send(8'h3C, 0, 1, 1, 1, 0, 0); send(8'hC3, 0, 0, 0, 0, 0, 1);
        check_all("R6 overrun");
        // R10 write clears errors not full
        pulse_wr(); chk(status == 8'h02, "R10 write", status, 8'h02);
        pulse_rd();
        // R7 parity errors, even and odd
        send(8'h81, 0, 1, 0, 0, 1, 0); check_all("R7 even");
        pulse_rd(); pulse_wr();
        send(8'h81, 0, 1, 1, 0, 1, 0); check_all("R7 odd");
        pulse_rd(); pulse_wr();
        // R8 framing error, then a clean frame right after
        send(8'h55, 0, 0, 0, 0, 0, 1); check_all("R8 frame");
        pulse_rd(); pulse_wr();
        send(8'h66, 0, 0, 0, 0, 0, 0); check_all("R8 recover");
        pulse_rd();
        // R2 short glitch is rejected
        rxd = 0; repeat (4) @(negedge clk); rxd = 1;
        repeat (3 * OS) @(negedge clk);
        check_all("R2 glitch");
        // R1 slower tick
        div = 2; send(8'h19, 0, 1, 0, 1, 0, 0); check_all("R1 div2"); div = 1;
        // R11 disable clears flags and ignores frames
        send(8'h77, 0, 0, 0, 0, 0, 1);
        rx_en = 0; @(negedge clk); @(negedge clk);
        e_full = 0; e_ovr = 0; e_par = 0; e_frm = 0;
        chk(status == 8'h00, "R11 clear", status, 0);
        send(8'h12, 0, 0, 0, 0, 0, 0); check_all("R11 ignore");
        rx_en = 1; repeat (4) @(negedge clk);

        // random mix: R1 R6 R7 R8 R9 R10
        for (int n = 0; n < 40; n++) begin
            logic [7:0] d = 8'($urandom);
            logic l7 = 1'($urandom), pe = 1'($urandom), po = 1'($urandom), s2 = 1'($urandom);
            logic bp = ($urandom % 6 == 0), bs = ($urandom % 6 == 0);
            send(d, l7, pe, po, s2, bp, bs);
            check_all("R1 R9 random");
            if ($urandom % 2 == 0) pulse_rd();
            if ($urandom % 3 == 0) pulse_wr();
        end
        summary();
    end
endmodule